// File: doc/BRIEF.md
# Parallel Binary-to-Residue Converter

This block turns an unsigned binary word into its residues with respect to a fixed set of moduli in a single parallel pass, with no iterative division. The input word is cut into equal slices of a parameterised width. Every slice has its own small constant table for every modulus. Each table entry holds the slice value times the slice's power-of-two weight, already reduced by that modulus. For each modulus, a tree of two-input modulo adders then folds the table outputs into the final residue.

A one-cycle strobe captures the word. The residues appear together on a packed output bus one clock later, qualified by a valid flag. The modulus list, the slice width and the input width are fixed at elaboration. The tables are computed from those parameters by constant functions, so no table file is needed. Elaboration stops with an error if a modulus is below 2, if the moduli are not pairwise coprime, or if the slice width would make the tables too large. Residues identify the word uniquely only while it stays below the product of the moduli. Words at or above that product still produce their true residues.

Top module: `rns_fwd_conv`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first strobe, `valid_o` is 0 and `res_o` is all zeros.
- R2: `valid_o` is 1 in exactly the cycle that follows a cycle in which `start_i` was 1, and 0 otherwise.
- R3: For each modulus index i, the field `res_o[i*RES_W +: RES_W]` equals the captured `data_i` modulo the i-th modulus. The default modulus list is 7, 8 and 9 for fields 0, 1 and 2, with RES_W = 4.
- R4: Every residue field presented while `valid_o` is 1 is strictly less than its modulus.
- R5: While `start_i` is low, `res_o` keeps its last value, whatever `data_i` does.
- R6: The extreme inputs convert correctly. Input 0 gives all-zero residues, and the all-ones input 4095 gives residues 0, 7 and 0.
- R7: Inputs at or above the product of the moduli (504 by default) give their true residues rather than wrapped values. For example, 504 gives 0, 0, 0 and 1000 gives 6, 0, 1.
- R8: Strobes on consecutive cycles each yield their own result one cycle later, so a new word can be accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Capture strobe for `data_i` |
| data_i | input | IN_W | Unsigned binary word to convert |
| res_o | output | NUM_MOD*RES_W | Packed residues, field i for modulus i |
| valid_o | output | 1 | Residues on `res_o` are new this cycle |

## Verification
Each residue is due exactly one clock edge after the cycle in which its strobe was sampled high. `valid_o` drops on the edge after that, unless another strobe follows. The bench drives inputs on falling edges. It reads results on the next falling edge, which falls between the capturing edge and the edge after it. It then checks that the value still holds one falling edge later while `data_i` is changed with the strobe low. Expected residues come from a plain modulo function in the bench. They are tested on directed extremes, on multiples of the modulus product, on back-to-back strobes and on seeded random words.

// File: rtl/rns_fwd_pkg.sv
package rns_fwd_pkg;

   // Greatest common divisor, used for the coprimality check at elaboration.
   function automatic int unsigned gcd_u(input int unsigned a, input int unsigned b);
      int unsigned x;
      int unsigned y;
      int unsigned t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   // Table entry: (val * 2^shift) mod m, with the weight built by repeated
   // doubling so nothing grows beyond the modulus.
   function automatic int unsigned rom_entry(input int unsigned val,
                                             input int unsigned shift,
                                             input int unsigned m);
      int unsigned w;
      w = 1 % m;
      for (int unsigned s = 0; s < shift; s++) begin
         w = (w * 2) % m;
      end
      return ((val % m) * w) % m;
   endfunction

endpackage

// File: rtl/rns_slice_rom.sv
module rns_slice_rom #(
   parameter int unsigned SLICE_W = 4,
   parameter int unsigned RES_W   = 4,
   parameter int unsigned MODULUS = 7,
   parameter int unsigned SHIFT   = 0
) (
   input  logic [SLICE_W-1:0] addr_i,
   output logic [RES_W-1:0]   val_o
);
   localparam int unsigned DEPTH = 1 << SLICE_W;

   logic [RES_W-1:0] tbl [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      assign tbl[e] = RES_W'(rns_fwd_pkg::rom_entry(e, SHIFT, MODULUS));
   end

   assign val_o = tbl[addr_i];
endmodule

// File: rtl/rns_madd2.sv
module rns_madd2 #(
   parameter int unsigned RES_W   = 4,
   parameter int unsigned MODULUS = 7
) (
   input  logic [RES_W-1:0] a_i,
   input  logic [RES_W-1:0] b_i,
   output logic [RES_W-1:0] y_i
);
   localparam logic [RES_W:0] MOD_V = (RES_W+1)'(MODULUS);

   logic [RES_W:0] sum;
   logic [RES_W:0] dif;

   assign sum = {1'b0, a_i} + {1'b0, b_i};
   assign dif = sum - MOD_V;
   assign y_i = (sum >= MOD_V) ? dif[RES_W-1:0] : sum[RES_W-1:0];
endmodule

// File: rtl/rns_mod_tree.sv
module rns_mod_tree #(
   parameter int unsigned NUM_OPS = 3,
   parameter int unsigned RES_W   = 4,
   parameter int unsigned MODULUS = 7
) (
   input  logic [NUM_OPS*RES_W-1:0] ops_i,
   output logic [RES_W-1:0]         sum_o
);
   localparam int unsigned LVLS   = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 0;
   localparam int unsigned LEAVES = 1 << LVLS;

   // Heap-ordered nodes: leaves at LEAVES..2*LEAVES-1, root at 1.
   logic [RES_W-1:0] node [1:2*LEAVES-1];

   for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
      if (l < NUM_OPS) begin : g_op
         assign node[LEAVES+l] = ops_i[l*RES_W +: RES_W];
      end else begin : g_pad
         assign node[LEAVES+l] = '0;
      end
   end

   for (genvar n = 1; n < LEAVES; n++) begin : g_add
      rns_madd2 #(.RES_W(RES_W), .MODULUS(MODULUS)) add_i (
         .a_i(node[2*n]),
         .b_i(node[2*n+1]),
         .y_i(node[n])
      );
   end

   assign sum_o = node[1];
endmodule

// File: rtl/rns_fwd_conv.sv
module rns_fwd_conv #(
   parameter int unsigned IN_W    = 12,
   parameter int unsigned SLICE_W = 4,
   parameter int unsigned NUM_MOD = 3,
   parameter logic [NUM_MOD*8-1:0] MODULI = {8'd9, 8'd8, 8'd7},
   localparam int unsigned RES_W  = rns_fwd_conv_res_w(MODULI)
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     start_i,
   input  logic [IN_W-1:0]          data_i,
   output logic [NUM_MOD*RES_W-1:0] res_o,
   output logic                     valid_o
);
   function automatic int unsigned rns_fwd_conv_res_w(input logic [NUM_MOD*8-1:0] mv);
      int unsigned mx;
      mx = 2;
      for (int i = 0; i < NUM_MOD; i++) begin
         if (int'(mv[i*8 +: 8]) > mx) mx = int'(mv[i*8 +: 8]);
      end
      return $clog2(mx);
   endfunction

   localparam int unsigned NUM_SLICE = (IN_W + SLICE_W - 1) / SLICE_W;
   localparam int unsigned PAD_W     = NUM_SLICE * SLICE_W;

   // Elaboration checks on the parameter set.
   if (SLICE_W < 1 || SLICE_W > 10) begin : g_bad_slice
      $error("rns_fwd_conv: SLICE_W out of range 1..10");
   end
   if (IN_W < 1) begin : g_bad_inw
      $error("rns_fwd_conv: IN_W must be positive");
   end
   for (genvar a = 0; a < NUM_MOD; a++) begin : g_chk_a
      if (int'(MODULI[a*8 +: 8]) < 2) begin : g_bad_mod
         $error("rns_fwd_conv: modulus below 2");
      end
      for (genvar b = a + 1; b < NUM_MOD; b++) begin : g_chk_b
         if (rns_fwd_pkg::gcd_u(int'(MODULI[a*8 +: 8]), int'(MODULI[b*8 +: 8])) != 1) begin : g_bad_pair
            $error("rns_fwd_conv: moduli not pairwise coprime");
         end
      end
   end

   logic [PAD_W-1:0]         data_pad;
   logic [NUM_MOD*RES_W-1:0] res_d;
   logic [NUM_MOD*RES_W-1:0] res_q;
   logic                     valid_q;

   assign data_pad = PAD_W'(data_i);

   for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
      localparam int unsigned MOD_I = int'(MODULI[i*8 +: 8]);
      logic [NUM_SLICE*RES_W-1:0] part;

      for (genvar j = 0; j < NUM_SLICE; j++) begin : g_slice
         rns_slice_rom #(
            .SLICE_W(SLICE_W), .RES_W(RES_W), .MODULUS(MOD_I), .SHIFT(j*SLICE_W)
         ) rom_i (
            .addr_i(data_pad[j*SLICE_W +: SLICE_W]),
            .val_o (part[j*RES_W +: RES_W])
         );
      end

      rns_mod_tree #(
         .NUM_OPS(NUM_SLICE), .RES_W(RES_W), .MODULUS(MOD_I)
      ) tree_i (
         .ops_i(part),
         .sum_o(res_d[i*RES_W +: RES_W])
      );
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         valid_q <= 1'b0;
         res_q   <= '0;
      end else begin
         valid_q <= start_i;
         if (start_i) res_q <= res_d;
      end
   end

   assign res_o   = res_q;
   assign valid_o = valid_q;
endmodule

// File: rtl/rns_fwd_conv_chk.sv
module rns_fwd_conv_chk #(
   parameter int unsigned IN_W    = 12,
   parameter int unsigned NUM_MOD = 3,
   parameter logic [NUM_MOD*8-1:0] MODULI = {8'd9, 8'd8, 8'd7},
   parameter int unsigned RES_W   = 4
) (
   input logic                     clk_i,
   input logic                     rst_ni,
   input logic                     start_i,
   input logic [IN_W-1:0]          data_i,
   input logic [NUM_MOD*RES_W-1:0] res_o,
   input logic                     valid_o
);
   AST_VALID_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> valid_o); // R2
   AST_NO_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> !valid_o); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> $stable(res_o)); // R5

   for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
      localparam int unsigned MOD_I = int'(MODULI[i*8 +: 8]);
      AST_RES_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         valid_o |-> (32'(res_o[i*RES_W +: RES_W]) < MOD_I)); // R4
      AST_RES_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         start_i |=> (32'(res_o[i*RES_W +: RES_W]) == (32'($past(data_i)) % MOD_I))); // R3
   end
endmodule

bind rns_fwd_conv rns_fwd_conv_chk #(
   .IN_W(IN_W), .NUM_MOD(NUM_MOD), .MODULI(MODULI), .RES_W(RES_W)
) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .data_i(data_i),
   .res_o(res_o), .valid_o(valid_o)
);

// File: tb/rns_fwd_conv_tb_top.sv
module rns_fwd_conv_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int IN_W  = 12;
   localparam int RES_W = 4;
   localparam int NMOD  = 3;
   localparam int WATCHDOG_CYC = 20000;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  start = 1'b0;
   logic [IN_W-1:0]       data = '0;
   logic [NMOD*RES_W-1:0] res;
   logic                  valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rns_fwd_conv dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_i(data),
      .res_o(res), .valid_o(valid)
   );

   function automatic int modv(input int idx);
      return (idx == 0) ? 7 : (idx == 1) ? 8 : 9;
   endfunction

   function automatic int fld(input logic [NMOD*RES_W-1:0] r, input int idx);
      return int'(r[idx*RES_W +: RES_W]);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_res(input string req, input int x);
      for (int i = 0; i < NMOD; i++) begin
         check(fld(res, i) == x % modv(i), req, fld(res, i), x % modv(i));
         check(fld(res, i) < modv(i), "R4", fld(res, i), modv(i) - 1);
      end
   endtask

   // One strobe, result read at the next falling edge, then hold check (R5).
   task automatic convert(input string req, input int x);
      logic [NMOD*RES_W-1:0] snap;
      start = 1'b1;
      data  = IN_W'(x);
      @(negedge clk);
      start = 1'b0;
      data  = IN_W'(x ^ 12'hA5A);
      check(valid == 1'b1, "R2", int'(valid), 1);
      check_res(req, x);
      snap = res;
      @(negedge clk);
      check(valid == 1'b0, "R2", int'(valid), 0);
      check(res == snap, "R5", int'(res), int'(snap));
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd2718);
      repeat (3) @(negedge clk);
      // R1: held in reset
      check(valid == 1'b0, "R1", int'(valid), 0);
      check(res == '0, "R1", int'(res), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(valid == 1'b0, "R1", int'(valid), 0);
      check(res == '0, "R1", int'(res), 0);

      // R6 extremes
      convert("R6", 0);
      convert("R6", 4095);
      // R3 directed small values and slice boundaries
      convert("R3", 1);
      convert("R3", 7);
      convert("R3", 8);
      convert("R3", 9);
      convert("R3", 15);
      convert("R3", 16);
      convert("R3", 255);
      convert("R3", 256);
      convert("R3", 503);
      // R7 beyond the modulus product
      convert("R7", 504);
      convert("R7", 1000);
      convert("R7", 3024);

      // R8 back-to-back strobes
      begin
         int seqv [4] = '{100, 2049, 77, 3999};
         start = 1'b1;
         data  = IN_W'(seqv[0]);
         for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            check(valid == 1'b1, "R8", int'(valid), 1);
            check_res("R8", seqv[k-1]);
            data = IN_W'(seqv[k]);
         end
         @(negedge clk);
         start = 1'b0;
         check(valid == 1'b1, "R8", int'(valid), 1);
         check_res("R8", seqv[3]);
         @(negedge clk);
         check(valid == 1'b0, "R2", int'(valid), 0);
      end

      // R3 seeded random words
      for (int n = 0; n < 300; n++) begin
         convert("R3", int'($urandom() % 4096));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < WATCHDOG_CYC; c++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG_CYC);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule